// File: doc/BRIEF.md
# GPIO Port with Single-Pin Event Interrupt

This block is a general-purpose I/O controller with a pin count set by a parameter (16 by default), reached over a simple register bus. Software sets each pin's direction, drives output levels, and reads input levels that have been synchronised to the block clock. A control bit gates the block's clock activity. While that bit is clear, the sampled inputs and the event logic hold their state.

One pin at a time can be watched for a chosen edge. A packed event-mode word names the pin and the edge, and enables the detector. A detected edge sets a GPIO status bit. A keypad event arrives as a plain level input and appears beside it as a second status bit. A mask register gates both status bits onto a single interrupt line. A bus read of the status register clears the GPIO bit, so software must test the GPIO source before the keypad source. An edge that arrives in the same cycle as that read is not lost.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset, reads return the following values: direction 0xFFFF, output 0x0000, control 0x0000, event mode 0x0000 and mask 0x0003. After reset, pad_oe is 0, pad_out is 0 and irq is 0.
- R2: The direction register is at address 1 and reads back as written. A 1 bit makes a pin an input and a 0 bit makes it an output. pad_oe is the bitwise inverse of this register from the cycle after the write.
- R3: The output register is at address 0. It takes full-word writes, reads back as written, and drives pad_out from the cycle after the write.
- R4: The input register is at address 2. It returns pad_in after a two-flop synchroniser: a level applied before clock edge k can be read after edge k+1. Writes to this address have no effect.
- R5: The control register is at address 3, and bit 5 is the clock enable. While this bit is 0, the input register holds its value and no pin edge sets the GPIO status bit.
- R6: The event-mode register is at address 4. Bit 0 enables the detector and bits 4:1 select the pin. Bit 5 selects the edge: 1 is rising and 0 is falling. A matching edge on the selected pin sets status bit 1. Edges on other pins, and edges in the other direction, do not set it.
- R7: The status register is at address 5. Bit 0 equals the level of kbd_evt and bit 1 is the GPIO event flag. A bus read of this register clears bit 1 and leaves bit 0 unchanged.
- R8: The mask register is at address 6. Bit 0 masks the keypad source and bit 1 masks the GPIO source, and a 1 masks. irq is the OR of every status bit whose mask bit is 0.
- R9: If a status read and a new GPIO event fall in the same cycle, status bit 1 is left set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data (combinational) |
| pad_in | input | PINS | Pin levels from the pads |
| pad_out | output | PINS | Levels driven toward the pads |
| pad_oe | output | PINS | Per-pin output enable, 1 = drive |
| kbd_evt | input | 1 | Keypad event level |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with the default of 16 pins. At that size, the pin-select field fills bits 4:1 and the edge bit falls at bit 5. This lets the bench exercise every selectable pin, including pin 15 at the top of the field, and both edge polarities. Directed cases place a status read in the exact cycle where a detected edge lands, and they toggle the clock enable while a watched pin moves. A seeded random phase mixes changing pin levels, keypad activity, mode and mask rewrites, and status reads, and compares the results against a cycle model kept in the bench.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int ADDR_W    = 3;
  localparam int CLKEN_BIT = 5;
  localparam int SRC_KBD   = 0;
  localparam int SRC_GPIO  = 1;
  localparam int SRC_N     = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_OUT  = 3'd0,
    REG_DIR  = 3'd1,
    REG_IN   = 3'd2,
    REG_CTRL = 3'd3,
    REG_MODE = 3'd4,
    REG_STAT = 3'd5,
    REG_MASK = 3'd6,
    REG_NONE = 3'd7
  } reg_addr_e;

  // Edge test on one pin: rising when rise_sel is 1, falling otherwise.
  function automatic logic edge_seen(logic now_v, logic old_v, logic rise_sel);
    return rise_sel ? (now_v & ~old_v) : (~now_v & old_v);
  endfunction
endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q, cur_q, prv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else if (en) begin
      meta_q <= din;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;

  AST_FROZEN_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cur)); // R5
endmodule

// File: rtl/gpio_evt_edge.sv
module gpio_evt_edge import gpio_evt_pkg::*; #(
  parameter int W    = 16,
  parameter int SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            arm,
  input  logic            rise_sel,
  input  logic [SELW-1:0] pin_sel,
  input  logic [W-1:0]    cur,
  input  logic [W-1:0]    prv,
  output logic            hit
);
  logic now_bit, old_bit;

  assign now_bit = cur[pin_sel];
  assign old_bit = prv[pin_sel];
  assign hit     = en & arm & edge_seen(now_bit, old_bit, rise_sel);

  AST_HIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (arm && en)); // R6
  AST_HIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (now_bit == rise_sel)); // R6
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port import gpio_evt_pkg::*; #(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  input  logic              kbd_evt,
  output logic              irq
);
  localparam int SELW     = (PINS > 1) ? $clog2(PINS) : 1;
  localparam int EDGE_BIT = SELW + 1;
  localparam int MODE_W   = SELW + 2;

  reg_addr_e         addr;
  logic [PINS-1:0]   dir_q, out_q;
  logic              clken_q;
  logic [MODE_W-1:0] mode_q;
  logic [SRC_N-1:0]  mask_q;
  logic              gpio_st_q;
  logic [SRC_N-1:0]  status;
  logic [PINS-1:0]   pin_now, pin_old;
  logic              gpio_hit, wr_en, rd_stat;

  assign addr    = reg_addr_e'(bus_addr);
  assign wr_en   = bus_sel & bus_wr;
  assign rd_stat = bus_sel & ~bus_wr & (addr == REG_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q   <= '1;
      out_q   <= '0;
      clken_q <= 1'b0;
      mode_q  <= '0;
      mask_q  <= '1;
    end else if (wr_en) begin
      case (addr)
        REG_OUT:  out_q   <= bus_wdata;
        REG_DIR:  dir_q   <= bus_wdata;
        REG_CTRL: clken_q <= bus_wdata[CLKEN_BIT];
        REG_MODE: mode_q  <= bus_wdata[MODE_W-1:0];
        REG_MASK: mask_q  <= bus_wdata[SRC_N-1:0];
        default:  ;
      endcase
    end
  end

  gpio_evt_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(clken_q),
    .din(pad_in), .cur(pin_now), .prv(pin_old)
  );

  gpio_evt_edge #(.W(PINS), .SELW(SELW)) u_edge (
    .clk(clk), .rst_n(rst_n), .en(clken_q),
    .arm(mode_q[0]), .rise_sel(mode_q[EDGE_BIT]), .pin_sel(mode_q[SELW:1]),
    .cur(pin_now), .prv(pin_old), .hit(gpio_hit)
  );

  // A new event wins over the clearing read in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) gpio_st_q <= 1'b0;
    else        gpio_st_q <= gpio_hit | (gpio_st_q & ~rd_stat);
  end

  always_comb begin
    status           = '0;
    status[SRC_KBD]  = kbd_evt;
    status[SRC_GPIO] = gpio_st_q;
  end

  assign irq     = |(status & ~mask_q);
  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;

  always_comb begin
    bus_rdata = '0;
    case (addr)
      REG_OUT:  bus_rdata = out_q;
      REG_DIR:  bus_rdata = dir_q;
      REG_IN:   bus_rdata = pin_now;
      REG_CTRL: bus_rdata[CLKEN_BIT] = clken_q;
      REG_MODE: bus_rdata[MODE_W-1:0] = mode_q;
      REG_STAT: bus_rdata[SRC_N-1:0] = status;
      REG_MASK: bus_rdata[SRC_N-1:0] = mask_q;
      default:  bus_rdata = '0;
    endcase
  end

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_DIR) |=> (pad_oe == ~$past(bus_wdata))); // R2
  AST_OUT_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_OUT) |=> (pad_out == $past(bus_wdata))); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !gpio_hit) |=> !gpio_st_q); // R7
  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_hit |=> gpio_st_q); // R9
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq); // R8
endmodule

// File: tb/gpio_evt_port_test.sv
module gpio_evt_port_test;
  localparam int PINS = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]      bus_addr = '0;
  logic [PINS-1:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
  logic            kbd_evt = 1'b0, irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_evt_port #(.PINS(PINS)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .kbd_evt(kbd_evt), .irq(irq)
  );

  // Bench cycle model, written from the requirements.
  logic [15:0] m_s1, m_s2, m_s3;
  logic        m_en, m_gst;
  logic [5:0]  m_mode;
  logic [1:0]  m_mask;

  function automatic logic model_hit(logic [15:0] now_v, logic [15:0] old_v,
                                     logic [5:0] mode, logic en);
    int p = int'(mode[4:1]);
    logic a = (now_v >> p) & 1'b1;
    logic b = (old_v >> p) & 1'b1;
    if (!en || !mode[0]) return 1'b0;
    return mode[5] ? (a && !b) : (!a && b);
  endfunction

  function automatic logic model_irq(logic gst, logic kb, logic [1:0] mask);
    return (kb && !mask[0]) || (gst && !mask[1]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_s3 <= '0;
      m_en <= 1'b0; m_gst <= 1'b0; m_mode <= '0; m_mask <= 2'b11;
    end else begin
      if (m_en) begin m_s1 <= pad_in; m_s2 <= m_s1; m_s3 <= m_s2; end
      m_gst <= model_hit(m_s2, m_s3, m_mode, m_en) ||
               (m_gst && !(bus_sel && !bus_wr && bus_addr == 3'd5));
      if (bus_sel && bus_wr) begin
        if (bus_addr == 3'd3) m_en   <= bus_wdata[5];
        if (bus_addr == 3'd4) m_mode <= bus_wdata[5:0];
        if (bus_addr == 3'd6) m_mask <= bus_wdata[1:0];
      end
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 pad_oe", pad_oe, 16'h0000);
    check("R1 pad_out", pad_out, 16'h0000);
    check("R1 irq", {15'd0, irq}, 16'h0000);
    idle(1);
    rd(3'd1, d); check("R1 dir", d, 16'hFFFF);
    rd(3'd0, d); check("R1 out", d, 16'h0000);
    rd(3'd3, d); check("R1 ctrl", d, 16'h0000);
    rd(3'd4, d); check("R1 mode", d, 16'h0000);
    rd(3'd6, d); check("R1 mask", d, 16'h0003);

    // R2 direction
    wr(3'd1, 16'h00F0);
    check("R2 pad_oe", pad_oe, 16'hFF0F);
    rd(3'd1, d); check("R2 readback", d, 16'h00F0);

    // R3 output register
    wr(3'd0, 16'hA5C3);
    check("R3 pad_out", pad_out, 16'hA5C3);
    rd(3'd0, d); check("R3 readback", d, 16'hA5C3);

    // R4 input synchroniser latency
    wr(3'd3, 16'h0020);
    pad_in = 16'h1234;
    idle(1);
    rd(3'd2, d); check("R4 one edge not yet", d, 16'h0000);
    rd(3'd2, d); check("R4 two edges", d, 16'h1234);
    wr(3'd2, 16'h0000);
    rd(3'd2, d); check("R4 write ignored", d, 16'h1234);

    // R5 freeze
    wr(3'd3, 16'h0000);
    rd(3'd3, d); check("R5 ctrl readback", d, 16'h0000);
    pad_in = 16'hFFFF;
    idle(4);
    rd(3'd2, d); check("R5 frozen input", d, 16'h1234);
    wr(3'd3, 16'h0020);
    rd(3'd3, d); check("R5 ctrl set", d, 16'h0020);
    pad_in = 16'h0000;
    idle(4);
    wr(3'd4, 16'h002F);  // enable, pin 7, rising
    rd(3'd4, d); check("R6 mode readback", d, 16'h002F);
    rd(3'd5, d);
    rd(3'd5, d); check("R7 cleared", d, 16'h0000);

    // R6 rising edge on pin 7
    pad_in[7] = 1'b1;
    idle(4);
    rd(3'd5, d); check("R6 rising sets", d, 16'h0002);
    rd(3'd5, d); check("R7 read clears", d, 16'h0000);
    pad_in[3] = 1'b1;
    idle(4);
    rd(3'd5, d); check("R6 other pin", d, 16'h0000);
    wr(3'd4, 16'h000F);  // falling
    pad_in[7] = 1'b0;
    idle(4);
    rd(3'd5, d); check("R6 falling sets", d, 16'h0002);
    pad_in[7] = 1'b1;
    idle(4);
    rd(3'd5, d); check("R6 wrong edge", d, 16'h0000);
    wr(3'd4, 16'h003F);  // pin 15 rising
    pad_in[15] = 1'b1;
    idle(4);
    rd(3'd5, d); check("R6 pin 15", d, 16'h0002);

    // R5 no event while frozen
    wr(3'd4, 16'h000F);
    wr(3'd3, 16'h0000);
    pad_in[7] = 1'b0;
    idle(4);
    rd(3'd5, d); check("R5 frozen no event", d, 16'h0000);
    wr(3'd3, 16'h0020);
    idle(4);
    rd(3'd5, d);

    // R7 keypad level, R8 mask
    kbd_evt = 1'b1;
    #1 check("R8 masked kbd", {15'd0, irq}, 16'h0000);
    idle(1);
    rd(3'd5, d); check("R7 kbd level", d, 16'h0001);
    rd(3'd5, d); check("R7 kbd not cleared", d, 16'h0001);
    wr(3'd6, 16'h0002);
    check("R8 kbd unmasked", {15'd0, irq}, 16'h0001);
    kbd_evt = 1'b0;
    #1 check("R8 kbd low", {15'd0, irq}, 16'h0000);
    idle(1);
    wr(3'd6, 16'h0001);
    wr(3'd4, 16'h002F);
    pad_in[7] = 1'b1;
    idle(3);
    #1 check("R8 gpio irq", {15'd0, irq}, 16'h0001);
    idle(1);
    rd(3'd5, d);
    #1 check("R8 gpio cleared", {15'd0, irq}, 16'h0000);

    // R9 read in the landing cycle
    pad_in[7] = 1'b0;
    wr(3'd4, 16'h002F);
    idle(4);
    rd(3'd5, d);
    pad_in[7] = 1'b1;
    idle(2);
    rd(3'd5, d); check("R9 before landing", d, 16'h0000);
    rd(3'd5, d); check("R9 event kept", d, 16'h0002);

    // Random phase against the model
    for (int i = 0; i < 3000; i++) begin
      int act;
      if ($urandom % 3 == 0) pad_in = pad_in ^ (16'h1 << ($urandom % 16));
      if ($urandom % 8 == 0) kbd_evt = ~kbd_evt;
      #1 check("R8 irq", {15'd0, irq}, {15'd0, model_irq(m_gst, kbd_evt, m_mask)});
      act = int'($urandom % 10);
      case (act)
        0: wr(3'd4, 16'(($urandom % 2) | (($urandom % 16) << 1) | (($urandom % 2) << 5)));
        1: wr(3'd6, 16'($urandom % 4));
        2: wr(3'd3, ($urandom % 5 == 0) ? 16'h0000 : 16'h0020);
        3, 4, 5: begin
          logic [15:0] e;
          e = {14'd0, m_gst, kbd_evt};
          rd(3'd5, d); check("R6 R7 R9 status", d, e);
        end
        6: begin
          logic [15:0] e;
          e = m_s2;
          rd(3'd2, d); check("R4 input", d, e);
        end
        default: idle(1);
      endcase
    end

    done = 1;
    report();
  end
endmodule